// File: doc/BRIEF.md
# Overclock Watchdog with Safe-Frequency Fallback

This block watches over a frequency setting that software has raised above its rated value. When it is enabled, it counts down a programmed number of seconds. A prescaler on the reference clock supplies the one-second tick. Software proves the system is still alive by pulsing a service strobe, which restarts the countdown. If the countdown runs out, the system has probably hung because of the overclock. The block then pulls an active-low reset line toward the system for a fixed number of reference cycles. It also raises a sticky status flag and replaces the frequency code it passes on with a programmed safe code.

In normal operation the block passes the current frequency code straight through. It also passes the request to run from directly programmed PLL dividers. After a timeout it forces the safe code and withdraws the divider request, so that the safe table setting takes effect. This fallback lasts until software clears the status flag. The register file and the PLL sit outside this block.

Top module: `ocwd_guard`

## Requirements
- R1: After reset, `sys_rst_n` is 1 and `wd_trip` is 0. `fsel_out` equals `fsel_cur` and `div_sel_out` equals `div_sel_in`.
- R2: While `wd_en` is 0 the countdown is frozen, and no timeout occurs however long the block waits.
- R3: A reload is a `wd_en` rising edge, a `kick` pulse, a `tmo_wr` pulse, or a status clear while tripped. With the block enabled, the timeout is registered exactly `tmo_secs` x `TICK_DIV` clock cycles after the edge that takes the reload.
- R4: A `kick` or `tmo_wr` pulse reloads the countdown with the present `tmo_secs`, so that the full interval restarts from that edge.
- R5: On timeout, `sys_rst_n` goes low on the same edge and stays low for exactly `RST_TICKS` (16) clock cycles.
- R6: `wd_trip` goes to 1 on timeout and stays at 1, even with `wd_en` at 0, until a `stat_clr` pulse clears it.
- R7: While `wd_trip` is 1, `fsel_out` equals `safe_code` and follows any change to it. Otherwise `fsel_out` equals `fsel_cur`.
- R8: While `wd_trip` is 1, `div_sel_out` is 0 whatever the value of `div_sel_in`.
- R9: A `tmo_secs` value of 0 acts as one second: the timeout comes `TICK_DIV` cycles after the reload.
- R10: When a `stat_clr` pulse and a timeout fall on the same edge, the timeout wins and `wd_trip` ends up at 1.
- R11: Clearing the status flag while enabled restarts a full countdown from the clearing edge, so a second timeout follows `tmo_secs` x `TICK_DIV` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wd_en | input | 1 | Watchdog enable (register bit) |
| tmo_secs | input | CNT_W | Timeout length in seconds |
| tmo_wr | input | 1 | One-cycle pulse: timeout register written |
| kick | input | 1 | One-cycle service strobe |
| stat_clr | input | 1 | One-cycle pulse: software writes 0 to the status flag |
| safe_code | input | CODE_W | Frequency code used after a timeout |
| fsel_cur | input | CODE_W | Active frequency code |
| div_sel_in | input | 1 | Request to use directly programmed dividers |
| fsel_out | output | CODE_W | Frequency code passed to the synthesizer |
| div_sel_out | output | 1 | Divider request passed to the synthesizer |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| wd_trip | output | 1 | Sticky timeout status |

## Verification
The reload is registered on the edge that samples the strobe. The timeout flag, the safe code and the reset pulse then appear together on the edge `tmo_secs` x `TICK_DIV` cycles later, and the reset rises again 16 edges after that. The bench drives and samples on falling edges. For each timeout it checks the cycle just before the due edge (nothing yet) and the cycle just after it (everything present), and it brackets the reset pulse the same way at cycles 15 and 16. A small `TICK_DIV` keeps these windows short.

// File: rtl/ocwd_guard.sv
module ocwd_guard #(
  parameter int TICK_DIV  = 1000000,
  parameter int CNT_W     = 8,
  parameter int CODE_W    = 5,
  parameter int RST_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wd_en,
  input  logic [CNT_W-1:0]  tmo_secs,
  input  logic              tmo_wr,
  input  logic              kick,
  input  logic              stat_clr,
  input  logic [CODE_W-1:0] safe_code,
  input  logic [CODE_W-1:0] fsel_cur,
  input  logic              div_sel_in,
  output logic [CODE_W-1:0] fsel_out,
  output logic              div_sel_out,
  output logic              sys_rst_n,
  output logic              wd_trip
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int RC_W  = $clog2(RST_TICKS + 1);

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic [RC_W-1:0]  rcnt;
  logic             en_q, tripped;
  logic             reload, running, tick, trip_now;

  assign reload   = tmo_wr | kick | (wd_en & ~en_q) | (stat_clr & tripped);
  assign running  = wd_en & ~tripped & ~reload;
  assign tick     = running & (pre == PRE_W'(TICK_DIV - 1));
  assign trip_now = tick & (cnt <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      cnt     <= '0;
      rcnt    <= '0;
      en_q    <= 1'b0;
      tripped <= 1'b0;
    end else begin
      en_q <= wd_en;
      if (trip_now) begin
        tripped <= 1'b1;
        rcnt    <= RC_W'(RST_TICKS);
      end else begin
        if (stat_clr) tripped <= 1'b0;
        if (rcnt != '0) rcnt <= rcnt - 1'b1;
      end
      if (reload) begin
        pre <= '0;
        cnt <= tmo_secs;
      end else if (running) begin
        if (tick) begin
          pre <= '0;
          cnt <= (cnt <= CNT_W'(1)) ? '0 : cnt - 1'b1;
        end else begin
          pre <= pre + 1'b1;
        end
      end
    end
  end

  assign wd_trip     = tripped;
  assign sys_rst_n   = (rcnt == '0);
  assign fsel_out    = tripped ? safe_code : fsel_cur;
  assign div_sel_out = div_sel_in & ~tripped;

  // R2
  trip_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_trip) |-> $past(wd_en));

  // R6
  trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_trip && !stat_clr) |=> wd_trip);

  // R5
  rst_on_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_trip) |-> !sys_rst_n);

  // R5
  rst_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= RC_W'(RST_TICKS));

  // R3
  trip_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_trip) |-> $past(running));

endmodule

// File: tb/tb_ocwd_guard.sv
module tb_ocwd_guard;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 0, rst_n = 0;
  logic wd_en = 0, tmo_wr = 0, kick = 0, stat_clr = 0, div_sel_in = 0;
  logic [7:0] tmo_secs = 0;
  logic [4:0] safe_code = 0, fsel_cur = 0;
  logic [4:0] fsel_out;
  logic div_sel_out, sys_rst_n, wd_trip;
  int checks = 0, errors = 0;
  bit done = 0;

  ocwd_guard #(.TICK_DIV(DIV), .CNT_W(8), .CODE_W(5), .RST_TICKS(16)) dut (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .tmo_secs(tmo_secs), .tmo_wr(tmo_wr),
    .kick(kick), .stat_clr(stat_clr), .safe_code(safe_code), .fsel_cur(fsel_cur),
    .div_sel_in(div_sel_in), .fsel_out(fsel_out), .div_sel_out(div_sel_out),
    .sys_rst_n(sys_rst_n), .wd_trip(wd_trip));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; step(1); s = 0;
  endtask

  task automatic hard_reset();
    wd_en = 0; tmo_wr = 0; kick = 0; stat_clr = 0;
    rst_n = 0; step(2); rst_n = 1; step(1);
  endtask

  task automatic t_reset();
    fsel_cur = 5'h09; div_sel_in = 1;
    hard_reset();
    chk(sys_rst_n, 1, "R1 sys_rst_n");
    chk(wd_trip, 0, "R1 wd_trip");
    chk(fsel_out, 5'h09, "R1 fsel_out");
    chk(div_sel_out, 1, "R1 div_sel_out");
  endtask

  task automatic t_disabled();
    hard_reset();
    tmo_secs = 1; pulse(tmo_wr);
    step(100);
    chk(wd_trip, 0, "R2 no trip while disabled");
    chk(sys_rst_n, 1, "R2 no reset while disabled");
  endtask

  task automatic t_timeout();
    hard_reset();
    fsel_cur = 5'h03; safe_code = 5'h1A; div_sel_in = 1; tmo_secs = 3;
    wd_en = 1; step(1);
    step(3*DIV - 1);
    chk(wd_trip, 0, "R3 not yet tripped");
    chk(fsel_out, 5'h03, "R7 pass-through before trip");
    chk(div_sel_out, 1, "R8 divider pass before trip");
    step(1);
    chk(wd_trip, 1, "R3 trip at N*DIV");
    chk(sys_rst_n, 0, "R5 reset low on trip");
    chk(fsel_out, 5'h1A, "R7 safe code");
    chk(div_sel_out, 0, "R8 divider forced off");
    safe_code = 5'h07; #1;
    chk(fsel_out, 5'h07, "R7 follows safe code");
    step(15);
    chk(sys_rst_n, 0, "R5 low at cycle 15");
    step(1);
    chk(sys_rst_n, 1, "R5 high after 16");
    wd_en = 0; step(50);
    chk(wd_trip, 1, "R6 sticky while disabled");
    pulse(stat_clr);
    chk(wd_trip, 0, "R6 cleared");
    chk(fsel_out, 5'h03, "R7 pass-through after clear");
  endtask

  task automatic t_kick();
    hard_reset();
    tmo_secs = 2; wd_en = 1; step(1);
    step(2*DIV - 2);
    pulse(kick);
    step(2*DIV - 1);
    chk(wd_trip, 0, "R4 kick restarted interval");
    step(1);
    chk(wd_trip, 1, "R4 trip after kick interval");
  endtask

  task automatic t_rewrite();
    hard_reset();
    tmo_secs = 2; wd_en = 1; step(1);
    step(DIV);
    tmo_secs = 5; pulse(tmo_wr);
    step(5*DIV - 1);
    chk(wd_trip, 0, "R4 new count not yet expired");
    step(1);
    chk(wd_trip, 1, "R4 new count expired");
  endtask

  task automatic t_zero();
    hard_reset();
    tmo_secs = 0; wd_en = 1; step(1);
    step(DIV - 1);
    chk(wd_trip, 0, "R9 zero count before one second");
    step(1);
    chk(wd_trip, 1, "R9 zero count as one second");
  endtask

  task automatic t_restart_and_race();
    hard_reset();
    tmo_secs = 2; wd_en = 1; step(1);
    step(2*DIV);
    chk(wd_trip, 1, "R11 first trip");
    step(20);
    pulse(stat_clr);
    step(2*DIV - 1);
    chk(wd_trip, 0, "R11 restarted full interval");
    stat_clr = 1; step(1); stat_clr = 0;
    chk(wd_trip, 1, "R10 trip wins over clear");
    chk(sys_rst_n, 0, "R11 second reset pulse");
  endtask

  initial begin
    step(1);
    t_reset();
    t_disabled();
    t_timeout();
    t_kick();
    t_rewrite();
    t_zero();
    t_restart_and_race();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule